// File: doc/BRIEF.md
# Sticky-Collecting Mantissa Right Shifter

This block shifts a 128-bit mantissa right by a signed shift count. The mantissa is held as four 32-bit words. Word 0 is the most significant and occupies bits 127:96 of the mantissa port. Word 3 is the least significant and occupies bits 31:0. Every bit that leaves the bottom of the mantissa is ORed into a single sticky bit, and so is the sticky bit presented with the operand. A rounding stage further down the datapath can therefore see whether anything nonzero was discarded.

The shift works in two steps. First, whole 32-bit words move down and fill with zeros from the top. Then a residual shift of 0 to 31 bits crosses the word boundaries.

- Any count at or above the significant width (parameter `SIG_W`, 115 by default) takes a shortcut: the mantissa is cleared and sticky is forced to one.
- A count of zero or less is illegal. It raises an error flag instead of shifting.

The result is registered. A one-cycle done strobe marks the cycle after each accepted operand.

The control is a two-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No result is being presented. |
| `ST_DONE` | A fresh result is on the outputs. |

| Transition | Condition |
|---|---|
| `ST_IDLE -> ST_DONE` | `in_valid` is high. |
| `ST_DONE -> ST_DONE` | Another operand arrives back to back. |
| `ST_DONE -> ST_IDLE` | `in_valid` is low. |

Each operand is put into one of three classes:

| Class | Condition |
|---|---|
| `CLS_SHIFT` | Count from 1 to `SIG_W`-1. |
| `CLS_FLUSH` | Count of `SIG_W` or more. |
| `CLS_ILLEGAL` | Count of zero or less. |

Top module: `sticky_rshift`

## Requirements
- R1: While reset is asserted and after it is released, before any operand, `out_done`, `out_mant`, `out_sticky` and `out_err` are all zero.
- R2: `out_done` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise.
- R3: For a count s with 1 <= s <= `SIG_W`-1, `out_mant` equals `in_mant` logically shifted right by s bits, and `out_err` is 0. Bit 127 is the most significant bit of word 0.
- R4: For a count s in the legal range, `out_sticky` is 1 exactly when any of the s discarded low bits of `in_mant` is 1, or when `in_sticky` is 1.
- R5: An incoming sticky of 1 always gives `out_sticky` = 1 for any count.
- R6: For a count at or above `SIG_W` (read as two's complement, so up to 127 with the default width), `out_mant` is zero, `out_sticky` is 1 whatever `in_sticky` is, and `out_err` is 0.
- R7: For a count of zero or less (two's complement), `out_err` is 1, `out_mant` equals `in_mant` unchanged, and `out_sticky` equals `in_sticky`.
- R8: In a cycle with `in_valid` low, `out_mant`, `out_sticky` and `out_err` keep their previous values.
- R9: Operands presented on consecutive cycles are each accepted. Each result appears one cycle after its own operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_mant | input | 128 | Mantissa; word 0 in bits 127:96 |
| in_sticky | input | 1 | Sticky value carried in with the operand |
| in_shamt | input | 8 | Signed right-shift count |
| out_done | output | 1 | One-cycle strobe marking a fresh result |
| out_mant | output | 128 | Shifted mantissa |
| out_sticky | output | 1 | OR of discarded bits and the incoming sticky |
| out_err | output | 1 | Count was zero or negative |

## Verification
A wrong word-select or residual-shift path shows as a corrupted `out_mant` on the first `out_done` after a count that uses that path. A wrong discard mask shows as a wrong `out_sticky` in that same cycle. The shift count is swept over all 256 codes, so every whole-word distance, every residual distance, the width boundary and the sign boundary are each hit within a few cycles. Each count is paired with mantissas that place single ones at both ends of the vector, so a leaking or missing discard bit is caught at once. A state machine stuck in `ST_DONE` or `ST_IDLE` shows on `out_done` one cycle after the next operand or idle cycle.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } shr_state_e;

    typedef enum logic [1:0] {
        CLS_SHIFT   = 2'd0,
        CLS_FLUSH   = 2'd1,
        CLS_ILLEGAL = 2'd2
    } shift_class_e;

endpackage

// File: rtl/shr_word_stage.sv
// Whole-word move: shifts the vector down by sel words and reports
// whether any dropped word held a one.
module shr_word_stage #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int SEL_W  = 2
) (
    input  logic [NWORDS*WORD_W-1:0] din,
    input  logic [SEL_W-1:0]         sel,
    output logic [NWORDS*WORD_W-1:0] dout,
    output logic                     lost
);

    logic [WORD_W-1:0] in_w  [NWORDS];
    logic [WORD_W-1:0] out_w [NWORDS];

    // Word 0 is the most significant slice of the vector.
    for (genvar i = 0; i < NWORDS; i++) begin : g_words
        assign in_w[i] = din[(NWORDS-i)*WORD_W-1 -: WORD_W];
        assign dout[(NWORDS-i)*WORD_W-1 -: WORD_W] = out_w[i];
    end

    always_comb begin
        for (int i = 0; i < NWORDS; i++) begin
            out_w[i] = '0;
            for (int k = 0; k <= i; k++) begin
                if (int'(sel) == k) begin
                    out_w[i] = in_w[i-k];
                end
            end
        end
    end

    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < NWORDS; i++) begin
            if (i >= NWORDS - int'(sel)) begin
                lost = lost | (|in_w[i]);
            end
        end
    end

endmodule

// File: rtl/shr_bit_stage.sv
// Residual shift of 0..WORD_W-1 bits across word boundaries.
module shr_bit_stage #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int AMT_W  = 5
) (
    input  logic [NWORDS*WORD_W-1:0] din,
    input  logic [AMT_W-1:0]         amt,
    output logic [NWORDS*WORD_W-1:0] dout,
    output logic                     lost
);

    logic [WORD_W-1:0] in_w  [NWORDS];
    logic [WORD_W-1:0] out_w [NWORDS];
    logic [WORD_W-1:0] drop_mask;

    for (genvar i = 0; i < NWORDS; i++) begin : g_words
        assign in_w[i] = din[(NWORDS-i)*WORD_W-1 -: WORD_W];
        assign dout[(NWORDS-i)*WORD_W-1 -: WORD_W] = out_w[i];
        if (i == 0) begin : g_top
            assign out_w[i] = in_w[i] >> amt;
        end else begin : g_low
            assign out_w[i] = WORD_W'({in_w[i-1], in_w[i]} >> amt);
        end
    end

    // Bits of the lowest word that fall off the bottom.
    assign drop_mask = ~({WORD_W{1'b1}} << amt);
    assign lost      = |(in_w[NWORDS-1] & drop_mask);

endmodule

// File: rtl/shr_ctrl.sv
// Done-strobe sequencer.
module shr_ctrl
    import shr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load,
    output logic done
);

    shr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load = in_valid;
        unique case (state_q)
            ST_IDLE: done = 1'b0;
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift
    import shr_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NWORDS  = 4,
    parameter int SIG_W   = 115,
    parameter int SHAMT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NWORDS*WORD_W-1:0]  in_mant,
    input  logic                      in_sticky,
    input  logic signed [SHAMT_W-1:0] in_shamt,
    output logic                      out_done,
    output logic [NWORDS*WORD_W-1:0]  out_mant,
    output logic                      out_sticky,
    output logic                      out_err
);

    localparam int MANT_W = NWORDS * WORD_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic signed [SHAMT_W-1:0] LIM  = SHAMT_W'(SIG_W);
    localparam logic signed [SHAMT_W-1:0] ZERO = '0;

    logic                 load;
    shift_class_e         cls;
    logic [SEL_W-1:0]     word_sel;
    logic [BIT_W-1:0]     bit_amt;
    logic [MANT_W-1:0]    mid_mant, shf_mant;
    logic                 word_lost, bit_lost;
    logic [MANT_W-1:0]    nxt_mant;
    logic                 nxt_sticky, nxt_err;

    shr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .load     (load),
        .done     (out_done)
    );

    always_comb begin
        if (in_shamt <= ZERO)     cls = CLS_ILLEGAL;
        else if (in_shamt >= LIM) cls = CLS_FLUSH;
        else                      cls = CLS_SHIFT;
    end

    assign word_sel = in_shamt[BIT_W +: SEL_W];
    assign bit_amt  = in_shamt[BIT_W-1:0];

    shr_word_stage #(.WORD_W(WORD_W), .NWORDS(NWORDS), .SEL_W(SEL_W)) u_word (
        .din  (in_mant),
        .sel  (word_sel),
        .dout (mid_mant),
        .lost (word_lost)
    );

    shr_bit_stage #(.WORD_W(WORD_W), .NWORDS(NWORDS), .AMT_W(BIT_W)) u_bit (
        .din  (mid_mant),
        .amt  (bit_amt),
        .dout (shf_mant),
        .lost (bit_lost)
    );

    always_comb begin
        unique case (cls)
            CLS_SHIFT: begin
                nxt_mant   = shf_mant;
                nxt_sticky = in_sticky | word_lost | bit_lost;
                nxt_err    = 1'b0;
            end
            CLS_FLUSH: begin
                nxt_mant   = '0;
                nxt_sticky = 1'b1;
                nxt_err    = 1'b0;
            end
            CLS_ILLEGAL: begin
                nxt_mant   = in_mant;
                nxt_sticky = in_sticky;
                nxt_err    = 1'b1;
            end
            default: begin
                nxt_mant   = '0;
                nxt_sticky = 1'b0;
                nxt_err    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mant   <= '0;
            out_sticky <= 1'b0;
            out_err    <= 1'b0;
        end else if (load) begin
            out_mant   <= nxt_mant;
            out_sticky <= nxt_sticky;
            out_err    <= nxt_err;
        end
    end

endmodule

// File: rtl/sticky_rshift_chk.sv
module sticky_rshift_chk #(
    parameter int WORD_W  = 32,
    parameter int NWORDS  = 4,
    parameter int SIG_W   = 115,
    parameter int SHAMT_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [NWORDS*WORD_W-1:0]  in_mant,
    input logic                      in_sticky,
    input logic signed [SHAMT_W-1:0] in_shamt,
    input logic                      out_done,
    input logic [NWORDS*WORD_W-1:0]  out_mant,
    input logic                      out_sticky,
    input logic                      out_err
);

    localparam logic signed [SHAMT_W-1:0] LIM  = SHAMT_W'(SIG_W);
    localparam logic signed [SHAMT_W-1:0] ZERO = '0;

    // R2
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_sticky) && $stable(out_err)));

    // R5
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sticky) |=> out_sticky);

    // R6
    wide_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shamt >= LIM) |=> (out_mant == '0 && out_sticky && !out_err));

    // R7
    illegal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shamt <= ZERO) |=> (out_err && out_mant == $past(in_mant)));

endmodule

bind sticky_rshift sticky_rshift_chk #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS),
    .SIG_W  (SIG_W),
    .SHAMT_W(SHAMT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mant    (in_mant),
    .in_sticky  (in_sticky),
    .in_shamt   (in_shamt),
    .out_done   (out_done),
    .out_mant   (out_mant),
    .out_sticky (out_sticky),
    .out_err    (out_err)
);

// File: tb/tb_sticky_rshift.sv
`timescale 1ns/1ps
module tb_sticky_rshift;

    localparam int SIG_W = 115;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [127:0]       in_mant;
    logic               in_sticky;
    logic signed [7:0]  in_shamt;
    logic               out_done;
    logic [127:0]       out_mant;
    logic               out_sticky;
    logic               out_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sticky_rshift dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
        .in_sticky(in_sticky), .in_shamt(in_shamt), .out_done(out_done),
        .out_mant(out_mant), .out_sticky(out_sticky), .out_err(out_err)
    );

    task automatic cmp128(string req, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cmp1(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic expect_of(input logic [127:0] m, input logic st, input int s,
                             output logic [127:0] em, output logic es, output logic ee);
        logic [127:0] mask;
        if (s <= 0) begin
            em = m; es = st; ee = 1'b1;
        end else if (s >= SIG_W) begin
            em = '0; es = 1'b1; ee = 1'b0;
        end else begin
            mask = (128'd1 << s) - 128'd1;
            em = m >> s;
            es = st | ((m & mask) != 128'd0);
            ee = 1'b0;
        end
    endtask

    task automatic check_result(input logic [127:0] m, input logic st, input int s);
        logic [127:0] em;
        logic es, ee;
        expect_of(m, st, s, em, es, ee);
        cmp1("R2 done", out_done, 1'b1);
        if (s <= 0) begin
            cmp128("R7 mant", out_mant, em);
            cmp1("R7 sticky", out_sticky, es);
            cmp1("R7 err", out_err, ee);
        end else if (s >= SIG_W) begin
            cmp128("R6 mant", out_mant, em);
            cmp1("R6 sticky", out_sticky, es);
            cmp1("R6 err", out_err, ee);
        end else begin
            cmp128("R3 mant", out_mant, em);
            cmp1(st ? "R5 sticky" : "R4 sticky", out_sticky, es);
            cmp1("R3 err", out_err, ee);
        end
    endtask

    task automatic run_one(input logic [127:0] m, input logic st, input int s);
        logic [127:0] hm;
        logic hs, he;
        @(negedge clk);
        in_valid = 1'b1; in_mant = m; in_sticky = st; in_shamt = 8'(s);
        @(negedge clk);
        in_valid = 1'b0; in_mant = ~m; in_sticky = ~st; in_shamt = 8'(s + 7);
        check_result(m, st, s);
        hm = out_mant; hs = out_sticky; he = out_err;
        @(negedge clk);
        cmp1("R2 done low", out_done, 1'b0);
        cmp128("R8 hold mant", out_mant, hm);
        cmp1("R8 hold sticky", out_sticky, hs);
        cmp1("R8 hold err", out_err, he);
    endtask

    function automatic logic [127:0] pattern(int p);
        case (p)
            0: return '1;
            1: return 128'd1;
            2: return {1'b1, 127'd0};
            3: return {32{4'hA}};
            4: return 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
            5: return 128'h8000_0001_0000_0000_0000_0001_8000_0000;
            default: return '0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_sticky = 1'b0; in_shamt = '0;
        repeat (3) @(negedge clk);
        // R1 reset state while in reset
        cmp1("R1 done", out_done, 1'b0);
        cmp128("R1 mant", out_mant, '0);
        cmp1("R1 sticky", out_sticky, 1'b0);
        cmp1("R1 err", out_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp1("R1 done after release", out_done, 1'b0);
        cmp128("R1 mant after release", out_mant, '0);

        // Exhaustive count sweep over patterns and both incoming sticky values
        for (int p = 0; p < 7; p++) begin
            for (int st = 0; st < 2; st++) begin
                for (int s = -128; s < 128; s++) begin
                    run_one(pattern(p), st[0], s);
                end
            end
        end

        // R9 back-to-back operands
        @(negedge clk);
        in_valid = 1'b1; in_mant = pattern(4); in_sticky = 1'b0; in_shamt = 8'sd37;
        @(negedge clk);
        check_result(pattern(4), 1'b0, 37);
        in_mant = pattern(0); in_sticky = 1'b0; in_shamt = 8'sd100;
        @(negedge clk);
        in_valid = 1'b0;
        cmp1("R9 done second", out_done, 1'b1);
        cmp128("R9 mant second", out_mant, pattern(0) >> 100);
        cmp1("R9 sticky second", out_sticky, 1'b1);
        @(negedge clk);
        cmp1("R9 done drops", out_done, 1'b0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule